// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block owns the instruction address of a small 16-bit core with separate instruction and data memories. Each clock it looks at the instruction word now on the fetch bus, one register value read by the register file, and the 16-bit condition word, and works out the address that execution continues at. That address is shown on `pc_next` and is loaded into the program counter at the end of the instruction.

The core retires one instruction every two clocks. The first clock fetches and decodes, and the second executes and stores. An internal phase bit tracks the two clocks. The sequencer raises `step` in the second clock when the instruction may commit. The block covers five kinds of flow: fall-through, relative jump, jump-and-link, return through a register, and branch on a single condition bit. For jump-and-link it hands the register file the address to save, together with a write strobe.

Top module: `pcb_unit`

## Requirements
- R1: While `rst` is high the program counter is forced to 0, so the first fetch after reset is from address 0. `link_we` is low while reset is applied.
- R2: The program counter changes only on a clock edge that ends the execute phase with `step` high. If `step` is low in that phase, the counter keeps its value.
- R3: The opcode is `instr[3:0]`. Opcodes 0, 1 and 2 (memory operations) and 8 to 15 (arithmetic) commit to pc + 1, and the sum wraps from 0xFFFF to 0x0000.
- R4: Opcode 3 is a relative jump. `instr[15:8]` is an offset, sign-extended to 16 bits, and the target is pc + offset + 1 modulo 2^16.
- R5: Opcode 4 is jump-and-link. It jumps exactly as opcode 3 does, so offset 0 falls through. On the committing edge it pulses `link_we`, with `link_val` equal to the pc of the jump-and-link instruction. `link_we` is never high for any other opcode.
- R6: Opcode 5 is a return. The register named by `instr[7:4]` is read outside the block and arrives on `reg_val`, and the target is `reg_val` + 1 modulo 2^16.
- R7: Opcode 6 branches when `cond[instr[7:4]]` is 0. Opcode 7 branches when that bit is 1. A taken branch goes to pc + sign-extended `instr[15:8]` + 1. A branch not taken goes to pc + 1. No other bit of `cond` has any influence.
- R8: During the execute phase `pc_next` shows the value the counter takes if the instruction commits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Commit strobe, raised only in the execute phase |
| instr | input | 16 | Instruction word from the fetch bus |
| reg_val | input | 16 | Value of the register named by `instr[7:4]` |
| cond | input | 16 | Condition register contents |
| pc | output | 16 | Current program counter |
| pc_next | output | 16 | Address the counter moves to on commit |
| link_val | output | 16 | Return address written by jump-and-link |
| link_we | output | 1 | Register-file write strobe for jump-and-link |

## Verification
The assertions assume that `step` is raised only in the execute phase. They also assume that `instr`, `reg_val` and `cond` stay constant across both clocks of an instruction, because the target is computed from the values present on the committing edge. The bench drives every instruction through a task that holds its operands for two clocks. The task raises `step` only after the phase has turned to execute, which is one clock after a fetch-phase start. It steers the counter to chosen start addresses with return instructions, so the sweeps over offsets, condition bits and masks also reach addresses that wrap.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    // Instruction classes that this block must tell apart (low four bits of the word)
    localparam logic [3:0] OPC_JMP  = 4'd3;
    localparam logic [3:0] OPC_LINK = 4'd4;
    localparam logic [3:0] OPC_RET  = 4'd5;
    localparam logic [3:0] OPC_BRZ  = 4'd6;
    localparam logic [3:0] OPC_BRN  = 4'd7;

    // Source the next address is taken from
    typedef enum logic [1:0] {
        FLOW_SEQ = 2'd0,
        FLOW_REL = 2'd1,
        FLOW_RET = 2'd2
    } pcb_flow_e;

endpackage

// File: rtl/pcb_phase.sv
module pcb_phase (
    input  logic clk,
    input  logic rst,
    output logic exec_phase
);
    typedef struct packed {
        logic phase;
    } phase_st_t;

    phase_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.phase = ~st_q.phase;
        if (rst) begin
            st_d.phase = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign exec_phase = st_q.phase;
endmodule

// File: rtl/pcb_decode.sv
module pcb_decode
    import pcb_pkg::*;
#(
    parameter int INSTR_W = 16,
    parameter int OP_W    = 4,
    parameter int SEL_W   = 4,
    parameter int OFF_W   = 8
) (
    input  logic [INSTR_W-1:0]   instr,
    input  logic [(1<<SEL_W)-1:0] cond,
    output pcb_flow_e            flow,
    output logic                 link_req,
    output logic [OFF_W-1:0]     offset
);
    localparam int SEL_LO = OP_W;
    localparam int SEL_HI = OP_W + SEL_W - 1;
    localparam int OFF_LO = INSTR_W - OFF_W;

    typedef struct packed {
        pcb_flow_e  flow;
        logic       link;
    } dec_t;

    logic [OP_W-1:0]  op;
    logic [SEL_W-1:0] sel;
    logic             cbit;
    dec_t             dec_d;

    assign op     = instr[OP_W-1:0];
    assign sel    = instr[SEL_HI:SEL_LO];
    assign offset = instr[INSTR_W-1:OFF_LO];
    assign cbit   = cond[sel];

    always_comb begin
        dec_d.flow = FLOW_SEQ;
        dec_d.link = 1'b0;
        unique case (op)
            OP_W'(OPC_JMP):  dec_d.flow = FLOW_REL;
            OP_W'(OPC_LINK): begin
                dec_d.flow = FLOW_REL;
                dec_d.link = 1'b1;
            end
            OP_W'(OPC_RET):  dec_d.flow = FLOW_RET;
            OP_W'(OPC_BRZ):  dec_d.flow = cbit ? FLOW_SEQ : FLOW_REL;
            OP_W'(OPC_BRN):  dec_d.flow = cbit ? FLOW_REL : FLOW_SEQ;
            default:         dec_d.flow = FLOW_SEQ;
        endcase
    end

    assign flow     = dec_d.flow;
    assign link_req = dec_d.link;
endmodule

// File: rtl/pcb_target.sv
module pcb_target
    import pcb_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8
) (
    input  logic [ADDR_W-1:0] pc_cur,
    input  logic [ADDR_W-1:0] reg_val,
    input  logic [OFF_W-1:0]  offset,
    input  pcb_flow_e         flow,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFF_W;

    logic [ADDR_W-1:0] off_x;

    generate
        if (EXT_W > 0) begin : g_ext
            assign off_x = {{EXT_W{offset[OFF_W-1]}}, offset};
        end else begin : g_trunc
            assign off_x = offset[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        unique case (flow)
            FLOW_REL: target = pc_cur + off_x + ADDR_W'(1);
            FLOW_RET: target = reg_val + ADDR_W'(1);
            default:  target = pc_cur + ADDR_W'(1);
        endcase
    end
endmodule

// File: rtl/pcb_unit.sv
module pcb_unit
    import pcb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16,
    parameter int OP_W    = 4,
    parameter int SEL_W   = 4,
    parameter int OFF_W   = 8,
    localparam int COND_W = 1 << SEL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               step,
    input  logic [INSTR_W-1:0] instr,
    input  logic [ADDR_W-1:0]  reg_val,
    input  logic [COND_W-1:0]  cond,
    output logic [ADDR_W-1:0]  pc,
    output logic [ADDR_W-1:0]  pc_next,
    output logic [ADDR_W-1:0]  link_val,
    output logic               link_we
);
    typedef struct packed {
        logic [ADDR_W-1:0] pc;
    } pc_st_t;

    pc_st_t            st_d, st_q;
    logic              exec_phase;
    pcb_flow_e         flow;
    logic              link_req;
    logic [OFF_W-1:0]  offset;
    logic [ADDR_W-1:0] target;
    logic              commit;

    pcb_phase u_phase (
        .clk        (clk),
        .rst        (rst),
        .exec_phase (exec_phase)
    );

    pcb_decode #(
        .INSTR_W (INSTR_W),
        .OP_W    (OP_W),
        .SEL_W   (SEL_W),
        .OFF_W   (OFF_W)
    ) u_decode (
        .instr    (instr),
        .cond     (cond),
        .flow     (flow),
        .link_req (link_req),
        .offset   (offset)
    );

    pcb_target #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W)
    ) u_target (
        .pc_cur  (st_q.pc),
        .reg_val (reg_val),
        .offset  (offset),
        .flow    (flow),
        .target  (target)
    );

    assign commit = exec_phase & step;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            st_d.pc = target;
        end
        if (rst) begin
            st_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc       = st_q.pc;
    assign pc_next  = target;
    assign link_val = st_q.pc;
    assign link_we  = commit & link_req & ~rst;
endmodule

// File: rtl/pcb_unit_chk.sv
module pcb_unit_chk #(
    parameter int ADDR_W  = 16,
    parameter int INSTR_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               step,
    input logic               phase,
    input logic [INSTR_W-1:0] instr,
    input logic [ADDR_W-1:0]  pc,
    input logic [ADDR_W-1:0]  pc_next,
    input logic [ADDR_W-1:0]  link_val,
    input logic               link_we
);
    // R1: reset leaves the counter at zero
    p_reset_zero_r1: assert property (@(posedge clk) rst |=> pc == '0);

    // R2: without a commit strobe the counter holds
    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pc));

    // Input assumption: commit strobe only in execute phase
    p_step_in_exec_r2: assert property (@(posedge clk) disable iff (rst)
        step |-> phase);

    // R8: a commit loads the value shown on pc_next
    p_commit_loads_r8: assert property (@(posedge clk) disable iff (rst)
        (step && phase) |=> pc == $past(pc_next));

    // R3: arithmetic opcodes fall through
    p_alu_seq_r3: assert property (@(posedge clk) disable iff (rst)
        (step && phase && instr[3]) |=> pc == $past(pc) + ADDR_W'(1));

    // R5: link strobe only for jump-and-link, carrying the current pc
    p_link_r5: assert property (@(posedge clk) disable iff (rst)
        link_we |-> (instr[3:0] == 4'd4 && link_val == pc && step));
endmodule

bind pcb_unit pcb_unit_chk #(
    .ADDR_W  (ADDR_W),
    .INSTR_W (INSTR_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .phase    (exec_phase),
    .instr    (instr),
    .pc       (pc),
    .pc_next  (pc_next),
    .link_val (link_val),
    .link_we  (link_we)
);

// File: tb/pcb_unit_tb.sv
module pcb_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step = 1'b0;
    logic [15:0] instr = 16'h0;
    logic [15:0] reg_val = 16'h0;
    logic [15:0] cond = 16'h0;
    logic [15:0] pc, pc_next, link_val;
    logic        link_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pcb_unit u_dut (
        .clk(clk), .rst(rst), .step(step), .instr(instr), .reg_val(reg_val),
        .cond(cond), .pc(pc), .pc_next(pc_next), .link_val(link_val), .link_we(link_we)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] rel(input logic [15:0] p, input logic [7:0] off);
        return p + {{8{off[7]}}, off} + 16'd1;
    endfunction

    // Starts and ends at a negedge in the fetch phase
    task automatic run(input logic [15:0] ins, input logic [15:0] rv, input logic [15:0] cr,
                       input logic [15:0] exp_nxt, input bit exp_we, input string req);
        logic [15:0] pc0;
        pc0 = pc;
        instr = ins; reg_val = rv; cond = cr; step = 1'b0;
        @(posedge clk); @(negedge clk);
        step = 1'b1;
        #0;
        chk(pc_next == exp_nxt, {req, "/R8 pc_next"}, pc_next, exp_nxt);
        chk(link_we == exp_we, {req, "/R5 link_we"}, {15'd0, link_we}, {15'd0, exp_we});
        if (exp_we) chk(link_val == pc0, "R5 link_val", link_val, pc0);
        @(posedge clk); @(negedge clk);
        step = 1'b0;
        chk(pc == exp_nxt, {req, " pc"}, pc, exp_nxt);
    endtask

    task automatic set_pc(input logic [15:0] v);
        run(16'h00F5, v - 16'd1, 16'h0, v, 1'b0, "R6");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(pc == 16'h0, "R1 reset pc", pc, 16'h0);
        chk(link_we == 1'b0, "R1 reset link_we", {15'd0, link_we}, 16'h0);
        rst = 1'b0;
        // first instruction runs from address 0
        run(16'h0008, 16'h0, 16'h0, 16'h0001, 1'b0, "R1");

        // R3: all fall-through opcodes, including wrap at top of memory
        for (int op = 0; op < 16; op++) begin
            if (op >= 3 && op <= 7) continue;
            for (int k = 0; k < 4; k++) begin
                logic [15:0] b;
                b = (k == 0) ? 16'hFFFF : 16'(op * 4099 + k * 257);
                set_pc(b);
                run({12'hAB5, 4'(op)}, 16'h1234, 16'hFFFF, b + 16'd1, 1'b0, "R3");
            end
        end

        // R4 / R5: every offset for jump and jump-and-link
        for (int off = 0; off < 256; off++) begin
            logic [15:0] b;
            b = 16'(off * 251) ^ 16'hFF80;
            set_pc(b);
            run({8'(off), 4'h7, 4'd3}, 16'h0, 16'h0, rel(b, 8'(off)), 1'b0, "R4");
            set_pc(b);
            run({8'(off), 4'hF, 4'd4}, 16'h0, 16'h0, rel(b, 8'(off)), 1'b1, "R5");
        end

        // R6: return through register values, including 0xFFFF
        for (int v = 0; v < 256; v++) begin
            logic [15:0] r;
            r = (v == 255) ? 16'hFFFF : 16'(v * 263);
            run({8'h5A, 4'(v), 4'd5}, r, 16'h0, r + 16'd1, 1'b0, "R6");
        end

        // R7: every mask, both bit values, every offset, both branch kinds
        for (int m = 0; m < 16; m++) begin
            for (int bv = 0; bv < 2; bv++) begin
                for (int off = 0; off < 256; off++) begin
                    logic [15:0] cr, b;
                    cr = bv[0] ? (16'h1 << m) : ~(16'h1 << m);
                    b = 16'(off * 97 + m * 4001);
                    set_pc(b);
                    run({8'(off), 4'(m), 4'd6}, 16'h0, cr,
                        bv[0] ? b + 16'd1 : rel(b, 8'(off)), 1'b0, "R7 zero");
                    set_pc(b);
                    run({8'(off), 4'(m), 4'd7}, 16'h0, cr,
                        bv[0] ? rel(b, 8'(off)) : b + 16'd1, 1'b0, "R7 one");
                end
            end
        end

        // R2: execute phase without step leaves the counter alone
        for (int k = 0; k < 4; k++) begin
            logic [15:0] b;
            b = 16'(k * 1111 + 5);
            set_pc(b);
            instr = (k[0]) ? 16'h0403 : 16'h0005; reg_val = 16'h7777; step = 1'b0;
            @(posedge clk); @(negedge clk);
            chk(pc == b, "R2 hold fetch", pc, b);
            chk(link_we == 1'b0, "R2 no link", {15'd0, link_we}, 16'h0);
            @(posedge clk); @(negedge clk);
            chk(pc == b, "R2 hold exec", pc, b);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule